// File: doc/BRIEF.md
# Lane-Split Adder/Subtractor

This unit adds, subtracts or negates two 16-bit operands as a set of independent lanes. The lanes are chosen while the circuit runs. A 3-bit split vector picks which nibble boundaries cut the carry chain, so one word can be treated as a single 16-bit value, as two bytes, as four nibbles, or as any uneven mix of these. Each lane takes its own carry-in and reports its own carry-out. Both carry bits sit at the index of the lane's lowest nibble.

The unit has no clock and no state. A datapath stage instantiates it wherever packed-lane integer arithmetic is needed, and the result is valid in the same cycle that the operands change. Arithmetic is unsigned and wraps within each lane.

Top module: `lane_split_addsub`

## Requirements
- R1: Split bit k (k = 0..2) set cuts the datapath between nibble k and nibble k+1, at bit 4(k+1). No carry passes a cut, and nibbles with no cut between them share one carry chain.
- R2: With op code 2'b00 (add), each lane's result is the lane's bits of a plus the lane's bits of b plus the carry-in bit at the lane's lowest nibble index, truncated to the lane width.
- R3: With op code 2'b01 (subtract), each lane computes a + ~b + carry-in, truncated to the lane. A carry-in of 1 therefore gives the exact difference a - b modulo the lane size.
- R4: With op code 2'b10 (negate), each lane's result is the two's-complement negation of that lane of a. The b operand and the carry-in vector have no effect on it.
- R5: A lane's carry-out is 1 when its full-precision add or subtract sum exceeds the lane width. That bit appears at carry-out index (lowest bit of the lane)/4. Every carry-out bit that is not a lane's lowest nibble is 0. Carry-in bits that are not at a lane's lowest nibble are ignored.
- R6: In negate mode, every carry-out bit is 0.
- R7: Every split value works, including uneven ones such as 3'b001 and 3'b101, by the boundary rule of R1.
- R8: The outputs follow the inputs combinationally, within the same cycle.
- R9: The unused op code 2'b11 behaves exactly like add.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| a_i | input | 16 | First operand (the only operand used by negate) |
| b_i | input | 16 | Second operand |
| split_i | input | 3 | Lane cut vector; bit k cuts above nibble k |
| cin_i | input | 4 | Carry-in, one bit per nibble; only the bits at lane-low nibbles are used |
| op_i | input | 2 | 00 add, 01 subtract, 10 negate, 11 add |
| sum_o | output | 16 | Lane-wise result |
| cout_o | output | 4 | Carry-out, one bit at each lane's lowest nibble index |

## Verification
The bench goes after carries that sit right at a cut. An all-ones operand plus one must wrap to zero inside its own lane. A design that leaks across the cut would set bits in the next lane, and one that mislocates the carry-out would flag the wrong nibble. Uneven splits such as 3'b101 are mixed with carry-in bits placed inside a lane, which catches a design that injects those bits or derives lane starts from the wrong split bit. Negate runs with b and the carry-ins set to all ones, so a datapath that does not mask them shows a wrong value or a nonzero carry. Subtract with a carry-in of 1 across a borrow exposes a swapped inversion.

// File: rtl/lsa_pkg.sv
package lsa_pkg;

    typedef enum logic [1:0] {
        OP_ADD     = 2'b00,
        OP_SUB     = 2'b01,
        OP_NEG     = 2'b10,
        OP_ADD_ALT = 2'b11
    } lsa_op_e;

    localparam int LSA_NIB_W = 4;
    localparam int LSA_NIBS  = 4;

endpackage

// File: rtl/lsa_lane_map.sv
// Decodes the cut vector into per-nibble lane start and lane end flags.
module lsa_lane_map #(
    parameter  int NIBS   = 4,
    localparam int MASK_W = NIBS - 1
) (
    input  logic [MASK_W-1:0] split_i,
    output logic [NIBS-1:0]   start_o,
    output logic [NIBS-1:0]   end_o
);

    for (genvar n = 0; n < NIBS; n++) begin : g_map
        if (n == 0) begin : g_first
            assign start_o[n] = 1'b1;
        end else begin : g_rest
            assign start_o[n] = split_i[n-1];
        end
        if (n == NIBS - 1) begin : g_last
            assign end_o[n] = 1'b1;
        end else begin : g_inner
            assign end_o[n] = split_i[n];
        end
    end

endmodule

// File: rtl/lsa_nibble_add.sv
// One nibble of the chain: W-bit add with carry in and carry out.
module lsa_nibble_add #(
    parameter int W = 4
) (
    input  logic [W-1:0] x_i,
    input  logic [W-1:0] y_i,
    input  logic         c_i,
    output logic [W-1:0] s_o,
    output logic         c_o
);

    logic [W:0] wide;

    assign wide = {1'b0, x_i} + {1'b0, y_i} + {{W{1'b0}}, c_i};
    assign s_o  = wide[W-1:0];
    assign c_o  = wide[W];

endmodule

// File: rtl/lane_split_addsub.sv
module lane_split_addsub
    import lsa_pkg::*;
#(
    parameter  int NIB_W  = LSA_NIB_W,
    parameter  int NIBS   = LSA_NIBS,
    localparam int DW     = NIB_W * NIBS,
    localparam int MASK_W = NIBS - 1
) (
    input  logic [DW-1:0]     a_i,
    input  logic [DW-1:0]     b_i,
    input  logic [MASK_W-1:0] split_i,
    input  logic [NIBS-1:0]   cin_i,
    input  logic [1:0]        op_i,
    output logic [DW-1:0]     sum_o,
    output logic [NIBS-1:0]   cout_o
);

    lsa_op_e        op;
    logic           neg_mode;
    logic [DW-1:0]  opx;
    logic [DW-1:0]  opy;
    logic [NIBS-1:0] lane_start;
    logic [NIBS-1:0] lane_end;
    logic [NIBS-1:0] nib_cin;
    logic [NIBS-1:0] nib_cout;
    logic [NIBS-1:0] lane_carry;

    assign op = lsa_op_e'(op_i);

    // Operand steering: subtract inverts b, negate computes 0 + ~a + 1.
    always_comb begin
        neg_mode = 1'b0;
        opx      = a_i;
        opy      = b_i;
        case (op)
            OP_SUB: opy = ~b_i;
            OP_NEG: begin
                neg_mode = 1'b1;
                opx      = '0;
                opy      = ~a_i;
            end
            default: ;
        endcase
    end

    lsa_lane_map #(.NIBS(NIBS)) i_map (
        .split_i (split_i),
        .start_o (lane_start),
        .end_o   (lane_end)
    );

    for (genvar n = 0; n < NIBS; n++) begin : g_nib
        // Carry entering this nibble: fresh at a lane start, chained otherwise.
        if (n == 0) begin : g_c0
            assign nib_cin[n] = neg_mode | cin_i[n];
        end else begin : g_cn
            assign nib_cin[n] = lane_start[n] ? (neg_mode | cin_i[n]) : nib_cout[n-1];
        end

        lsa_nibble_add #(.W(NIB_W)) i_nib (
            .x_i (opx[n*NIB_W +: NIB_W]),
            .y_i (opy[n*NIB_W +: NIB_W]),
            .c_i (nib_cin[n]),
            .s_o (sum_o[n*NIB_W +: NIB_W]),
            .c_o (nib_cout[n])
        );

        // Carry leaving the lane, carried down to the lane's lowest nibble.
        if (n == NIBS - 1) begin : g_ltop
            assign lane_carry[n] = nib_cout[n];
        end else begin : g_lrest
            assign lane_carry[n] = lane_end[n] ? nib_cout[n] : lane_carry[n+1];
        end

        assign cout_o[n] = lane_start[n] & ~neg_mode & lane_carry[n];
    end

    always_comb begin
        // R5
        lane_cout_pos_chk: assert ((cout_o & ~{split_i, 1'b1}) == '0)
            else $error("carry-out outside a lane start");
        if (op == OP_NEG) begin
            // R6
            neg_no_carry_chk: assert (cout_o == '0)
                else $error("carry-out during negate");
            if (split_i == '0) begin
                // R4
                neg_inverse_chk: assert (DW'(sum_o + a_i) == '0)
                    else $error("negate does not invert a");
            end
        end
        if (op == OP_ADD && split_i == '0) begin
            // R2
            whole_add_chk: assert ({cout_o[0], sum_o} ==
                                   {1'b0, a_i} + {1'b0, b_i} + {{DW{1'b0}}, cin_i[0]})
                else $error("full-width add mismatch");
        end
        if (op == OP_ADD && split_i == '1) begin
            for (int n = 0; n < NIBS; n++) begin
                // R1
                nibble_iso_chk: assert (sum_o[n*NIB_W +: NIB_W] ==
                    NIB_W'(a_i[n*NIB_W +: NIB_W] + b_i[n*NIB_W +: NIB_W] + {{(NIB_W-1){1'b0}}, cin_i[n]}))
                    else $error("nibble lane not isolated");
            end
        end
    end

endmodule

// File: tb/test_lane_split_addsub.sv
module test_lane_split_addsub;

    localparam int PERIOD = 10;
    localparam int NV     = 11;

    typedef struct packed {
        logic [2:0]  split;
        logic [1:0]  op;
        logic [3:0]  cin;
        logic [15:0] a;
        logic [15:0] b;
        logic [15:0] res;
        logic [3:0]  cout;
    } vec_t;

    // split, op, cin, a, b, expected result, expected carry-out
    localparam vec_t VECS [0:NV-1] = '{
        '{3'b000, 2'b00, 4'b0000, 16'hFFFF, 16'h0001, 16'h0000, 4'b0001}, // R2 R5 wrap
        '{3'b111, 2'b00, 4'b0000, 16'hFFFF, 16'h0001, 16'hFFF0, 4'b0001}, // R1 no leak
        '{3'b111, 2'b00, 4'b0000, 16'hFFFF, 16'h1111, 16'h0000, 4'b1111}, // R1 R5 all lanes
        '{3'b010, 2'b01, 4'b0101, 16'h1234, 16'h0134, 16'h1100, 4'b0101}, // R3 bytes
        '{3'b000, 2'b10, 4'b1111, 16'h0001, 16'hFFFF, 16'hFFFF, 4'b0000}, // R4 R6
        '{3'b010, 2'b10, 4'b1111, 16'h0100, 16'hFFFF, 16'hFF00, 4'b0000}, // R4 R6 bytes
        '{3'b001, 2'b00, 4'b0000, 16'h00F8, 16'h0008, 16'h00F0, 4'b0001}, // R7 uneven
        '{3'b101, 2'b00, 4'b0110, 16'hFFFF, 16'h0011, 16'hF010, 4'b0011}, // R7 R5 inner cin
        '{3'b000, 2'b11, 4'b0000, 16'h0002, 16'h0003, 16'h0005, 4'b0000}, // R9
        '{3'b000, 2'b01, 4'b0001, 16'h0000, 16'h0001, 16'hFFFF, 4'b0000}, // R3 borrow
        '{3'b000, 2'b00, 4'b0000, 16'h0000, 16'h0000, 16'h0000, 4'b0000}  // R8 zero
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] a_i = '0;
    logic [15:0] b_i = '0;
    logic [2:0]  split_i = '0;
    logic [3:0]  cin_i = '0;
    logic [1:0]  op_i = '0;
    logic [15:0] sum_o;
    logic [3:0]  cout_o;
    int total = 0;
    int bad = 0;

    always #(PERIOD/2) clk = ~clk;

    lane_split_addsub i_lane_split_addsub (
        .a_i(a_i), .b_i(b_i), .split_i(split_i), .cin_i(cin_i),
        .op_i(op_i), .sum_o(sum_o), .cout_o(cout_o)
    );

    // Independent lane model built from the requirements.
    function automatic logic [19:0] model(input logic [2:0] sp, input logic [1:0] op,
                                          input logic [3:0] ci, input logic [15:0] a,
                                          input logic [15:0] b);
        logic [15:0] r = '0;
        logic [3:0]  c = '0;
        int lo = 0;
        for (int n = 0; n < 4; n++) begin
            if (n == 3 || sp[n]) begin
                int w = (n - lo + 1) * 4;
                logic [16:0] lm = (17'd1 << w) - 17'd1;
                logic [16:0] av = ({1'b0, a} >> (lo*4)) & lm;
                logic [16:0] bv = ({1'b0, b} >> (lo*4)) & lm;
                logic [16:0] s;
                if (op == 2'b01)      s = av + (~bv & lm) + {16'd0, ci[lo]};
                else if (op == 2'b10) s = (17'd0 - av) & lm;
                else                  s = av + bv + {16'd0, ci[lo]};
                r = r | 16'((s & lm) << (lo*4));
                if (op != 2'b10 && ((s >> w) & 17'd1) != 0) c[lo] = 1'b1;
                lo = n + 1;
            end
        end
        return {r, c};
    endfunction

    task automatic check(input string req, input logic [15:0] er, input logic [3:0] ec);
        total++;
        if (sum_o !== er || cout_o !== ec) begin
            bad++;
            $display("FAIL %s: split=%b op=%b cin=%b a=%h b=%h got res=%h cout=%b expected res=%h cout=%b",
                     req, split_i, op_i, cin_i, a_i, b_i, sum_o, cout_o, er, ec);
        end
    endtask

    task automatic drive(input logic [2:0] sp, input logic [1:0] op, input logic [3:0] ci,
                         input logic [15:0] a, input logic [15:0] b);
        @(negedge clk);
        split_i = sp; op_i = op; cin_i = ci; a_i = a; b_i = b;
        #1;
    endtask

    initial begin
        #(PERIOD * 200000);
        total++;
        bad++;
        $display("FAIL watchdog: run did not finish, got hung expected done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (2) @(posedge clk);
        rst = 1'b0;
        #1;
        // R8 quiet inputs give zero outputs at once
        check("R8 reset-idle", 16'h0000, 4'b0000);

        for (int i = 0; i < NV; i++) begin
            drive(VECS[i].split, VECS[i].op, VECS[i].cin, VECS[i].a, VECS[i].b);
            check($sformatf("R1-table vec %0d (R2 R3 R4 R5 R6 R7 R9)", i), VECS[i].res, VECS[i].cout);
        end

        // R4 negate ignores b and cin: same a, different b/cin, same result
        drive(3'b111, 2'b10, 4'b0000, 16'h1234, 16'h0000);
        check("R4 neg b=0", 16'hFEDC, 4'b0000);
        drive(3'b111, 2'b10, 4'b1111, 16'h1234, 16'hFFFF);
        check("R4 neg b=ffff", 16'hFEDC, 4'b0000);

        // R7 every split, every op, edge and random operands, compared to the model
        for (int sp = 0; sp < 8; sp++) begin
            for (int op = 0; op < 4; op++) begin
                for (int k = 0; k < 24; k++) begin
                    logic [15:0] a = 16'($urandom);
                    logic [15:0] b = 16'($urandom);
                    logic [3:0]  ci = 4'($urandom);
                    logic [19:0] e;
                    if (k == 0) begin a = 16'hFFFF; b = 16'hFFFF; ci = 4'b1111; end
                    if (k == 1) begin a = 16'h0000; b = 16'h0000; ci = 4'b0000; end
                    if (k == 2) begin a = 16'hFFFF; b = 16'h0000; ci = 4'b1111; end
                    if (k == 3) begin a = 16'h0000; b = 16'hFFFF; ci = 4'b0000; end
                    e = model(3'(sp), 2'(op), ci, a, b);
                    drive(3'(sp), 2'(op), ci, a, b);
                    check($sformatf("R7 model split=%0d op=%0d (R2 R3 R4 R5 R9)", sp, op),
                          e[19:4], e[3:0]);
                end
            end
        end

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule